// File: doc/BRIEF.md
# Shared Edge Interrupt With Group Lockout

This block turns a group of general-purpose input pins into one interrupt request. Each pin has its own enable bit and its own polarity bit. A set polarity bit makes a rising edge the trigger, and a clear polarity bit makes a falling edge the trigger. Every pin shares the same request line. There is no per-pin cause register, so the service routine reads the pins directly to find out which one fired.

When a pin triggers, the group is locked. No further request is raised until that pin, the lockout owner, goes back to its inactive level or has its enable cleared. The request is a one-cycle pulse. Edges that arrive while the group is locked are dropped, not stored. Pins have no priority among themselves. If several pins trigger in the same cycle, one pulse is raised and the lowest-numbered of them becomes the owner that must release the lockout. Acknowledging the request has no effect on the enables.

Each pin passes through a two-flop synchroniser before edge detection. The synchroniser flops reset to zero, so pins should sit low while reset is applied.

Top module: `shared_edge_irq`

## Requirements
- R1: While reset is asserted and right after it is released, `irq_o` is 0.
- R2: An enabled pin with polarity bit 1 that goes from 0 to 1 while the group is unlocked raises `irq_o` for exactly one cycle. The pulse is visible in the third cycle after the pin changes (two synchroniser stages plus one output register).
- R3: An enabled pin with polarity bit 0 that goes from 1 to 0 while the group is unlocked raises the same single-cycle pulse with the same latency.
- R4: A pin whose enable bit is 0 never raises `irq_o` on either edge, and it does not lock the group.
- R5: The edge opposite to a pin's polarity (falling with polarity 1, rising with polarity 0) raises no pulse.
- R6: While the owner stays enabled and at its active level (the level given by its polarity bit), edges on any other pin raise no pulse.
- R7: The lockout ends when the synchronised owner pin reads its inactive level. Later qualifying edges on any pin pulse again.
- R8: Clearing the owner's enable bit ends the lockout while the owner is still at its active level.
- R9: Edges dropped during a lockout are not queued. Releasing the lockout raises no pulse by itself.
- R10: When several pins trigger in the same cycle, exactly one pulse is raised and the lowest-numbered of them owns the lockout. Returning a higher-numbered one of them to its inactive level does not release the group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_pins_i | input | PIN_COUNT | Asynchronous pin levels |
| trig_en_i | input | PIN_COUNT | Per-pin interrupt enable (1 = enabled) |
| trig_pol_i | input | PIN_COUNT | Per-pin polarity (1 = rising edge triggers, active level high; 0 = falling edge triggers, active level low) |
| irq_o | output | 1 | Shared single-cycle interrupt request |

## Verification
A pin change driven just after one rising clock edge shows up on `irq_o` in the third cycle after it: two edges fill the synchroniser and a third loads the request register. The pulse is gone in the fourth cycle. A lockout release follows the same timing when the owner pin changes level, and takes effect at the next edge when the owner's enable is cleared. The driver therefore records the cycle index of each stimulus and queues the expected `irq_o` level for the second, third and fourth cycles after it. The monitor samples on falling clock edges and compares only the entries whose cycle index has come due. Every stimulus is followed by enough idle cycles that the expected windows never overlap.

// File: rtl/sei_pkg.sv
package sei_pkg;
  localparam int unsigned MAX_PINS = 32;
  localparam int unsigned IDX_W    = $clog2(MAX_PINS);

  typedef logic [MAX_PINS-1:0] pin_vec_t;
  typedef logic [IDX_W-1:0]    pin_idx_t;

  // Per-pin trigger: the edge selected by polarity, gated by enable.
  function automatic logic pin_hit(logic now_l, logic was_l, logic pol_l, logic en_l);
    logic rise_l, fall_l;
    rise_l = now_l & ~was_l;
    fall_l = ~now_l & was_l;
    return en_l & (pol_l ? rise_l : fall_l);
  endfunction

  // Lowest set bit index; used only to pick which pin releases the lockout.
  function automatic pin_idx_t first_set(pin_vec_t v);
    pin_idx_t r;
    r = '0;
    for (int i = MAX_PINS - 1; i >= 0; i--) begin
      if (v[i]) r = pin_idx_t'(i);
    end
    return r;
  endfunction

  // Mask of all bits strictly below idx.
  function automatic pin_vec_t below_mask(pin_idx_t idx);
    return (pin_vec_t'(1) << idx) - pin_vec_t'(1);
  endfunction
endpackage

// File: rtl/sei_pin_sync.sv
module sei_pin_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] prev_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;
  logic [WIDTH-1:0]             prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= '0;
    end else begin
      chain_q[0] <= raw_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      prev_q <= chain_q[STAGES-1];
    end
  end

  assign sync_o = chain_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/sei_edge_qualify.sv
module sei_edge_qualify #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] sync_i,
  input  logic [WIDTH-1:0] prev_i,
  input  logic [WIDTH-1:0] pol_i,
  input  logic [WIDTH-1:0] en_i,
  output logic [WIDTH-1:0] trig_o
);
  import sei_pkg::*;

  generate
    for (genvar p = 0; p < WIDTH; p++) begin : g_pin
      assign trig_o[p] = pin_hit(sync_i[p], prev_i[p], pol_i[p], en_i[p]);
    end
  endgenerate
endmodule

// File: rtl/sei_lockout.sv
module sei_lockout #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] trig_i,
  input  logic [WIDTH-1:0] sync_i,
  input  logic [WIDTH-1:0] en_i,
  input  logic [WIDTH-1:0] pol_i,
  output logic             irq_o
);
  import sei_pkg::*;

  pin_vec_t trig_w, sync_w, en_w, pol_w;
  assign trig_w = pin_vec_t'(trig_i);
  assign sync_w = pin_vec_t'(sync_i);
  assign en_w   = pin_vec_t'(en_i);
  assign pol_w  = pin_vec_t'(pol_i);

  logic     locked_q, irq_q;
  pin_idx_t owner_q;

  logic any_hit_w, owner_en_w, owner_active_w, release_w, grab_w;
  assign any_hit_w      = |trig_i;
  assign owner_en_w     = en_w[owner_q];
  assign owner_active_w = (sync_w[owner_q] == pol_w[owner_q]);
  assign release_w      = locked_q & (~owner_en_w | ~owner_active_w);
  assign grab_w         = ~locked_q & any_hit_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      owner_q  <= '0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= grab_w;
      if (grab_w) begin
        locked_q <= 1'b1;
        owner_q  <= first_set(trig_w);
      end else if (release_w) begin
        locked_q <= 1'b0;
      end
    end
  end

  assign irq_o = irq_q;

  // R2
  irq_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  // R2
  irq_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(any_hit_w));
  // R6
  lock_blocks_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> !irq_q);
  // R6
  lock_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && owner_en_w && owner_active_w) |=> locked_q);
  // R7
  release_inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && owner_en_w && !owner_active_w) |=> !locked_q);
  // R8
  release_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && !owner_en_w) |=> !locked_q);
  // R10
  owner_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_q) |-> ((($past(trig_w) & below_mask(owner_q)) == '0) &&
                         ((($past(trig_w) >> owner_q) & pin_vec_t'(1)) != '0)));
endmodule

// File: rtl/shared_edge_irq.sv
module shared_edge_irq #(
  parameter int unsigned PIN_COUNT  = 8,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PIN_COUNT-1:0] port_pins_i,
  input  logic [PIN_COUNT-1:0] trig_en_i,
  input  logic [PIN_COUNT-1:0] trig_pol_i,
  output logic                 irq_o
);
  // PIN_COUNT must not exceed sei_pkg::MAX_PINS; SYNC_DEPTH must be at least 1.
  logic [PIN_COUNT-1:0] sync_w, prev_w, trig_w;

  sei_pin_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_DEPTH)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (port_pins_i),
    .sync_o (sync_w),
    .prev_o (prev_w)
  );

  sei_edge_qualify #(.WIDTH(PIN_COUNT)) u_edge (
    .sync_i (sync_w),
    .prev_i (prev_w),
    .pol_i  (trig_pol_i),
    .en_i   (trig_en_i),
    .trig_o (trig_w)
  );

  sei_lockout #(.WIDTH(PIN_COUNT)) u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig_i (trig_w),
    .sync_i (sync_w),
    .en_i   (trig_en_i),
    .pol_i  (trig_pol_i),
    .irq_o  (irq_o)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !irq_o);
  // R4
  disabled_only_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_en_i == '0) |=> !irq_o);
endmodule

// File: tb/tb_shared_edge_irq.sv
module tb_shared_edge_irq;
  localparam int unsigned N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pins = '0;
  logic [N-1:0] en   = '1;
  logic [N-1:0] pol  = '1;
  logic         irq;

  shared_edge_irq #(.PIN_COUNT(N), .SYNC_DEPTH(2)) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .port_pins_i (pins),
    .trig_en_i   (en),
    .trig_pol_i  (pol),
    .irq_o       (irq)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    due;
    logic  val;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  task automatic check(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: irq actual=%0b expected=%0b (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Monitor: compare every expectation whose cycle has come due.
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
      exp_t e;
      e = sb_q.pop_front();
      check(irq, e.val, e.tag);
    end
  end

  // Driver: change pins, queue the expected irq window, then idle.
  task automatic drive(input logic [N-1:0] new_pins, input logic pulse, input string tag);
    int c;
    @(negedge clk);
    c = cyc;
    pins = new_pins;
    sb_q.push_back('{c + 2, 1'b0, tag});
    sb_q.push_back('{c + 3, pulse, tag});
    sb_q.push_back('{c + 4, 1'b0, tag});
    repeat (6) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [N-1:0] new_en, input logic [N-1:0] new_pol);
    @(negedge clk);
    en  = new_en;
    pol = new_pol;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(irq, 1'b0, "R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(irq, 1'b0, "R1 after reset");

    // R2 rising edge, then R5/R7 falling edge releases silently
    drive(8'b0000_0001, 1'b1, "R2 pin0 rise pulse");
    drive(8'b0000_0000, 1'b0, "R5 pin0 fall no pulse");

    // R6 lockout by pin1, R9 dropped edges, R7 release
    drive(8'b0000_0010, 1'b1, "R2 pin1 rise pulse");
    drive(8'b0000_0110, 1'b0, "R6 pin2 rise while locked");
    drive(8'b0000_0010, 1'b0, "R6 pin2 fall while locked");
    drive(8'b0000_0000, 1'b0, "R9 release raises nothing");
    drive(8'b0000_0100, 1'b1, "R7 pin2 rise after release");
    drive(8'b0000_0000, 1'b0, "R7 pin2 fall");

    // R3 falling-edge polarity on pin3, R8 enable-clear release
    set_cfg(8'hFF, 8'b1111_0111);
    drive(8'b0000_1000, 1'b0, "R5 pin3 rise with falling polarity");
    drive(8'b0000_0000, 1'b1, "R3 pin3 fall pulse");
    drive(8'b0001_0000, 1'b0, "R6 pin4 rise while pin3 owns");
    drive(8'b0000_0000, 1'b0, "R6 pin4 fall while locked");
    set_cfg(8'b1111_0111, 8'b1111_0111);
    drive(8'b0001_0000, 1'b1, "R8 pin4 rise after enable clear");
    drive(8'b0000_0000, 1'b0, "R8 pin4 fall");
    set_cfg(8'hFF, 8'b1111_0111);
    drive(8'b0000_1000, 1'b0, "R5 pin3 back high no pulse");

    // R4 disabled pin neither pulses nor locks
    set_cfg(8'b1101_1111, 8'b1111_0111);
    drive(8'b0010_1000, 1'b0, "R4 disabled pin5 rise");
    drive(8'b0000_1000, 1'b0, "R4 disabled pin5 fall");
    drive(8'b0100_1000, 1'b1, "R4 group unlocked pin6 rise");
    drive(8'b0000_1000, 1'b0, "R4 pin6 fall");

    // R10 simultaneous trigger, lowest index owns
    set_cfg(8'hFF, 8'b1111_0111);
    drive(8'b0010_1100, 1'b1, "R10 pins2+5 rise one pulse");
    drive(8'b0000_1100, 1'b0, "R10 pin5 fall no release");
    drive(8'b1000_1100, 1'b0, "R10 pin7 rise still locked");
    drive(8'b0000_1100, 1'b0, "R10 pin7 fall");
    drive(8'b0000_1000, 1'b0, "R10 owner pin2 fall releases");
    drive(8'b1000_1000, 1'b1, "R10 pin7 rise after owner release");
    drive(8'b0000_1000, 1'b0, "R10 pin7 fall");

    wait (sb_q.size() == 0);
    @(negedge clk);
    finish_run();
  end
endmodule